// File: doc/BRIEF.md
# Cartridge Bank Mapper with RAM Overlay

This block is the address decoder and bank logic of a game-console cartridge. It sits on an 8-bit CPU bus with a 16-bit address, a write data byte and separate read and write strobes. It steers each access to one of two memories: a program ROM built from 8 KiB banks, or a 16 KiB work RAM. It also passes the graphics address through to an 8 KiB character memory that is never banked, and it drives a nametable mirroring select.

Three control fields are loaded by CPU writes to decoded address groups: a 4-bit window bank, a RAM-off flag and a mirroring bit. The `$6000-$7FFF` window shows either the low half of work RAM or a selectable ROM bank. The upper 32 KiB always shows the last four ROM banks. While RAM is on, reads in `$B800-$D7FF` return the upper half of work RAM in place of that ROM. Writes to either RAM region always reach the RAM. The ROM size is a parameter, given as a count of 8 KiB banks.

Top module: `cart_overlay_mapper`

## Requirements
- R1: A CPU write to any address with top nibble 8 (`$8000-$8FFF`) loads data bits [3:0] into the window bank register. The upper four data bits are dropped.
- R2: A CPU write with top nibble E loads data bit 3 into `mirror_horiz` (1 = horizontal, 0 = vertical).
- R3: A CPU write with top nibble F loads data bit 4 into the RAM-off flag.
- R4: With RAM-off set, a read in `$6000-$7FFF` asserts `rom_cs` only. It drives `rom_addr` = (bank mod ROM_BANKS) * 8192 + (address - `$6000`).
- R5: With RAM-off clear, a read in `$6000-$7FFF` asserts `ram_cs` only, with `ram_addr` = address - `$6000`.
- R6: With RAM-off clear, a read in `$B800-$D7FF` asserts `ram_cs` only, with `ram_addr` = `$2000` + (address - `$B800`). `rom_cs` and `ram_cs` are never high together.
- R7: Any other read in `$8000-$FFFF` asserts `rom_cs` with `rom_addr` = (ROM_BANKS - 4 + address[14:13]) * 8192 + address[12:0].
- R8: A write in `$6000-$7FFF` or `$B800-$D7FF` asserts `ram_cs` and `ram_we` at the RAM offsets of R5/R6 whatever the RAM-off flag is. `ram_we` is never high without `cpu_wr`, and writes never assert `rom_cs`.
- R9: Writes to `$9000-$B7FF` and `$D800-$DFFF` change no control field and assert neither `ram_we` nor `rom_cs`.
- R10: `chr_addr` always equals `ppu_addr` (character bank 0).
- R11: While `rst_n` is low, the bank register and RAM-off flag are 0, and `mirror_horiz` follows `strap_horiz`.
- R12: A control write takes effect at the clock edge that ends its cycle; a read in the next cycle uses the new mapping. Control fields hold when not written.
- R13: Accesses below `$6000` assert neither chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_horiz | input | 1 | Mirroring default loaded on reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| ppu_addr | input | 13 | Graphics fetch address |
| rom_addr | output | ROM_AW | Program ROM byte address |
| rom_cs | output | 1 | Program ROM select (reads only) |
| ram_addr | output | 14 | Work RAM byte address |
| ram_cs | output | 1 | Work RAM select |
| ram_we | output | 1 | Work RAM write enable |
| chr_addr | output | 13 | Character memory address |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The address and select outputs are combinational, so each read or write is checked in its own cycle, a few nanoseconds after the bench drives the bus at the falling edge. A control field lands on the next rising edge. The bench therefore checks its effect only at the following falling edge, one cycle after the write, through a window read or `mirror_horiz`. The ignored-write cases are judged the same way: a later read must show an unchanged bank and flag, and `mirror_horiz` must be unchanged.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int unsigned PAGE_W     = 13;   // 8 KiB page offset width
  localparam int unsigned RAM_AW     = 14;   // 16 KiB work RAM
  localparam int unsigned BANK_SEL_W = 4;
  localparam int unsigned MIRROR_BIT = 3;
  localparam int unsigned RAMOFF_BIT = 4;
  localparam int unsigned FIXED_PAGES = 4;

  localparam logic [15:0] OVL_LO  = 16'hB800;
  localparam logic [15:0] OVL_HI  = 16'hD7FF;
  localparam logic [RAM_AW-1:0] OVL_BASE = RAM_AW'(16'h2000);

  // Window bank reduced into the ROM that exists.
  function automatic int unsigned wrap_bank(input logic [BANK_SEL_W-1:0] sel,
                                            input int unsigned nbanks);
    return int'(sel) % nbanks;
  endfunction

  // Upper 32 KiB: last four banks in order.
  function automatic int unsigned fixed_bank(input logic [1:0] slot,
                                             input int unsigned nbanks);
    return nbanks - FIXED_PAGES + int'(slot);
  endfunction

  function automatic logic in_overlay(input logic [15:0] a);
    return (a >= OVL_LO) && (a <= OVL_HI);
  endfunction

  function automatic logic [RAM_AW-1:0] overlay_offset(input logic [15:0] a);
    logic [15:0] d;
    d = a - OVL_LO;
    return OVL_BASE + RAM_AW'(d);
  endfunction
endpackage

// File: rtl/cart_ctrl_regs.sv
module cart_ctrl_regs
  import cart_map_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strap_horiz,
  input  logic                  wr,
  input  logic [3:0]            page,
  input  logic [7:0]            wdata,
  output logic [BANK_SEL_W-1:0] bank_q,
  output logic                  ram_off_q,
  output logic                  mirror_q,
  output logic                  bank_wr,
  output logic                  mode_wr,
  output logic                  mirror_wr
);
  // Named load events, one per control field.
  assign bank_wr   = wr && (page == 4'h8);
  assign mirror_wr = wr && (page == 4'hE);
  assign mode_wr   = wr && (page == 4'hF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q    <= '0;
      ram_off_q <= 1'b0;
      mirror_q  <= strap_horiz;
    end else begin
      if (bank_wr)   bank_q    <= wdata[BANK_SEL_W-1:0];
      if (mode_wr)   ram_off_q <= wdata[RAMOFF_BIT];
      if (mirror_wr) mirror_q  <= wdata[MIRROR_BIT];
    end
  end
endmodule

// File: rtl/cart_addr_decode.sv
module cart_addr_decode
  import cart_map_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 11,
  localparam int unsigned BANK_W = $clog2(ROM_BANKS),
  localparam int unsigned ROM_AW = BANK_W + PAGE_W
) (
  input  logic [15:0]           addr,
  input  logic                  rd,
  input  logic                  wr,
  input  logic [BANK_SEL_W-1:0] bank,
  input  logic                  ram_off,
  output logic [ROM_AW-1:0]     rom_addr,
  output logic                  rom_cs,
  output logic [RAM_AW-1:0]     ram_addr,
  output logic                  ram_cs,
  output logic                  ram_we
);
  logic              win_hit;
  logic              ovl_hit;
  logic [BANK_W-1:0] win_bank;
  logic [BANK_W-1:0] top_bank;

  assign win_hit  = (addr[15:13] == 3'b011);
  assign ovl_hit  = in_overlay(addr);
  assign win_bank = BANK_W'(wrap_bank(bank, ROM_BANKS));
  assign top_bank = BANK_W'(fixed_bank(addr[14:13], ROM_BANKS));

  always_comb begin
    rom_addr = '0;
    rom_cs   = 1'b0;
    ram_addr = '0;
    ram_cs   = 1'b0;
    ram_we   = 1'b0;
    if (win_hit) begin
      if (wr) begin
        ram_cs   = 1'b1;
        ram_we   = 1'b1;
        ram_addr = RAM_AW'(addr[PAGE_W-1:0]);
      end else if (rd) begin
        if (ram_off) begin
          rom_cs   = 1'b1;
          rom_addr = {win_bank, addr[PAGE_W-1:0]};
        end else begin
          ram_cs   = 1'b1;
          ram_addr = RAM_AW'(addr[PAGE_W-1:0]);
        end
      end
    end else if (addr[15]) begin
      if (wr) begin
        if (ovl_hit) begin
          ram_cs   = 1'b1;
          ram_we   = 1'b1;
          ram_addr = overlay_offset(addr);
        end
      end else if (rd) begin
        if (ovl_hit && !ram_off) begin
          ram_cs   = 1'b1;
          ram_addr = overlay_offset(addr);
        end else begin
          rom_cs   = 1'b1;
          rom_addr = {top_bank, addr[PAGE_W-1:0]};
        end
      end
    end
  end
endmodule

// File: rtl/cart_overlay_mapper.sv
module cart_overlay_mapper
  import cart_map_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 11,
  localparam int unsigned ROM_AW = $clog2(ROM_BANKS) + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_horiz,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  input  logic [12:0]       ppu_addr,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              rom_cs,
  output logic [13:0]       ram_addr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [12:0]       chr_addr,
  output logic              mirror_horiz
);
  logic [BANK_SEL_W-1:0] bank_q;
  logic                  ram_off_q;
  logic                  bank_wr;
  logic                  mode_wr;
  logic                  mirror_wr;

  cart_ctrl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_horiz(strap_horiz),
    .wr         (cpu_wr),
    .page       (cpu_addr[15:12]),
    .wdata      (cpu_wdata),
    .bank_q     (bank_q),
    .ram_off_q  (ram_off_q),
    .mirror_q   (mirror_horiz),
    .bank_wr    (bank_wr),
    .mode_wr    (mode_wr),
    .mirror_wr  (mirror_wr)
  );

  cart_addr_decode #(.ROM_BANKS(ROM_BANKS)) u_dec (
    .addr    (cpu_addr),
    .rd      (cpu_rd),
    .wr      (cpu_wr),
    .bank    (bank_q),
    .ram_off (ram_off_q),
    .rom_addr(rom_addr),
    .rom_cs  (rom_cs),
    .ram_addr(ram_addr),
    .ram_cs  (ram_cs),
    .ram_we  (ram_we)
  );

  // Character memory is a single fixed bank.
  assign chr_addr = ppu_addr;
endmodule

// File: rtl/cart_overlay_mapper_chk.sv
module cart_overlay_mapper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] cpu_addr,
  input logic [7:0]  cpu_wdata,
  input logic        cpu_wr,
  input logic        rom_cs,
  input logic        ram_cs,
  input logic        ram_we,
  input logic [12:0] ppu_addr,
  input logic [12:0] chr_addr,
  input logic        mirror_horiz,
  input logic [3:0]  bank_q,
  input logic        ram_off_q,
  input logic        bank_wr,
  input logic        mode_wr,
  input logic        mirror_wr
);
  assert_bank_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bank_wr |=> bank_q == $past(cpu_wdata[3:0]));

  assert_mirror_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mirror_wr |=> mirror_horiz == $past(cpu_wdata[3]));

  assert_mode_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> ram_off_q == $past(cpu_wdata[4]));

  assert_single_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_cs && ram_cs));

  assert_we_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (cpu_wr && ram_cs && !rom_cs));

  assert_ignored_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && ((cpu_addr >= 16'h9000 && cpu_addr < 16'hB800) ||
                (cpu_addr >= 16'hD800 && cpu_addr < 16'hE000)))
    |-> !(ram_we || rom_cs || bank_wr || mode_wr || mirror_wr));

  assert_chr_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chr_addr == ppu_addr);

  assert_bank_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr |=> $stable(bank_q));

  assert_flag_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(ram_off_q));

  assert_low_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr < 16'h6000) |-> !(rom_cs || ram_cs));
endmodule

bind cart_overlay_mapper cart_overlay_mapper_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_addr    (cpu_addr),
  .cpu_wdata   (cpu_wdata),
  .cpu_wr      (cpu_wr),
  .rom_cs      (rom_cs),
  .ram_cs      (ram_cs),
  .ram_we      (ram_we),
  .ppu_addr    (ppu_addr),
  .chr_addr    (chr_addr),
  .mirror_horiz(mirror_horiz),
  .bank_q      (bank_q),
  .ram_off_q   (ram_off_q),
  .bank_wr     (bank_wr),
  .mode_wr     (mode_wr),
  .mirror_wr   (mirror_wr)
);

// File: tb/cart_overlay_mapper_tb.sv
module cart_overlay_mapper_tb;
  localparam int NB = 11;
  localparam int RAW = $clog2(NB) + 13;

  logic clk = 0;
  logic rst_n = 0;
  logic strap_horiz = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0]  cpu_wdata = 0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [12:0] ppu_addr = 0;
  logic [RAW-1:0] rom_addr;
  logic rom_cs, ram_cs, ram_we, mirror_horiz;
  logic [13:0] ram_addr;
  logic [12:0] chr_addr;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  // Captured outputs of the last access.
  logic [31:0] c_rom_addr, c_ram_addr;
  logic c_rom_cs, c_ram_cs, c_ram_we;

  always #10 clk = ~clk;

  cart_overlay_mapper #(.ROM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_horiz(strap_horiz),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .ppu_addr(ppu_addr), .rom_addr(rom_addr), .rom_cs(rom_cs),
    .ram_addr(ram_addr), .ram_cs(ram_cs), .ram_we(ram_we),
    .chr_addr(chr_addr), .mirror_horiz(mirror_horiz)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_win(input int sel, input int a);
    return ((sel % NB) * 8192) + (a - 'h6000);
  endfunction
  function automatic logic [31:0] exp_top(input int a);
    return ((NB - 4 + (a - 'h8000) / 8192) * 8192) + (a % 8192);
  endfunction

  task automatic capture();
    #2;
    c_rom_addr = 32'(rom_addr); c_ram_addr = 32'(ram_addr);
    c_rom_cs = rom_cs; c_ram_cs = ram_cs; c_ram_we = ram_we;
  endtask

  task automatic bus_rd(input logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1;
    capture();
    cpu_rd = 0;
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    capture();
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    strap_horiz = strap; rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    chk("R11 mirror follows strap 1", mirror_horiz, 1);
    bus_wr(16'hF000, 8'h10);
    bus_rd(16'h6000);
    chk("R11 bank 0 after reset", c_rom_addr, exp_win(0, 'h6000));
    do_reset(1'b0);
    chk("R11 mirror follows strap 0", mirror_horiz, 0);
    bus_rd(16'h6123);
    chk("R11 flag clear after reset: RAM", c_ram_cs, 1);
    chk("R11 flag clear after reset: no ROM", c_rom_cs, 0);
  endtask

  task automatic t_window_rom();
    bus_wr(16'h8ABC, 8'hF3);
    bus_wr(16'hF000, 8'h10);
    bus_rd(16'h6000);
    chk("R1 R4 bank 3 low nibble", c_rom_addr, exp_win(3, 'h6000));
    chk("R4 rom_cs", c_rom_cs, 1);
    chk("R4 no ram_cs", c_ram_cs, 0);
    bus_rd(16'h7FFF);
    chk("R4 window top byte", c_rom_addr, exp_win(3, 'h7FFF));
    bus_wr(16'h8000, 8'h0D);
    bus_rd(16'h6555);
    chk("R4 bank 13 wraps", c_rom_addr, exp_win(13, 'h6555));
    bus_wr(16'hF000, 8'hEF);
    bus_rd(16'h6555);
    chk("R3 flag cleared -> RAM", c_ram_cs, 1);
  endtask

  task automatic t_ram_low();
    bus_rd(16'h7FFF);
    chk("R5 ram_addr", c_ram_addr, 'h1FFF);
    chk("R5 no rom_cs", c_rom_cs, 0);
  endtask

  task automatic t_overlay();
    bus_rd(16'hB800);
    chk("R6 overlay start", c_ram_addr, 'h2000);
    chk("R6 no rom_cs", c_rom_cs, 0);
    bus_rd(16'hD7FF);
    chk("R6 overlay end", c_ram_addr, 'h3FFF);
    bus_rd(16'hB7FF);
    chk("R7 just below overlay is ROM", c_rom_addr, exp_top('hB7FF));
    bus_rd(16'hD800);
    chk("R7 just above overlay is ROM", c_rom_addr, exp_top('hD800));
    bus_wr(16'hF000, 8'h10);
    bus_rd(16'hC000);
    chk("R6 overlay off when flag set", c_rom_addr, exp_top('hC000));
    chk("R6 overlay off: no ram_cs", c_ram_cs, 0);
    bus_wr(16'hF000, 8'h00);
  endtask

  task automatic t_fixed();
    for (int a = 'h8000; a < 'h10000; a += 'h2000) begin
      bus_rd(16'(a + 'h0AA));
      if (a != 'hC000) chk("R7 fixed bank", c_rom_addr, exp_top(a + 'h0AA));
    end
    bus_rd(16'hFFFF);
    chk("R7 last byte", c_rom_addr, (NB * 8192) - 1);
  endtask

  task automatic t_writes();
    bus_wr(16'hF000, 8'h10);
    bus_wr(16'h6010, 8'h55);
    chk("R8 low write with flag set: we", c_ram_we, 1);
    chk("R8 low write addr", c_ram_addr, 'h0010);
    bus_wr(16'hC004, 8'h66);
    chk("R8 overlay write with flag set: we", c_ram_we, 1);
    chk("R8 overlay write addr", c_ram_addr, 'h2804);
    chk("R8 write no rom_cs", c_rom_cs, 0);
    bus_wr(16'hF000, 8'h00);
    bus_wr(16'hD7FF, 8'h01);
    chk("R8 overlay write flag clear", c_ram_addr, 'h3FFF);
  endtask

  task automatic t_ignored();
    bus_wr(16'h8000, 8'h05);
    bus_wr(16'hE000, 8'h08);
    bus_wr(16'hF000, 8'h10);
    bus_wr(16'h9000, 8'h0A);
    chk("R9 9xxx no we", c_ram_we, 0);
    bus_wr(16'hA123, 8'hFF);
    chk("R9 Axxx no rom_cs", c_rom_cs, 0);
    bus_wr(16'hB7FF, 8'hE7);
    chk("R9 B7FF no we", c_ram_we, 0);
    bus_wr(16'hD800, 8'h00);
    chk("R9 D800 no we", c_ram_we, 0);
    bus_rd(16'h6000);
    chk("R9 bank unchanged", c_rom_addr, exp_win(5, 'h6000));
    chk("R9 flag unchanged", c_rom_cs, 1);
    chk("R9 mirror unchanged", mirror_horiz, 1);
    bus_wr(16'hF000, 8'h00);
  endtask

  task automatic t_mirror_timing();
    bus_wr(16'hEFFF, 8'hF7);
    chk("R2 vertical", mirror_horiz, 0);
    @(negedge clk);
    cpu_addr = 16'hE000; cpu_wdata = 8'h08; cpu_wr = 1;
    #2 chk("R12 no change before edge", mirror_horiz, 0);
    @(negedge clk);
    cpu_wr = 0;
    chk("R2 R12 horizontal next cycle", mirror_horiz, 1);
    bus_wr(16'h8000, 8'h02);
    bus_wr(16'hF000, 8'h10);
    bus_rd(16'h6001);
    chk("R12 bank used next cycle", c_rom_addr, exp_win(2, 'h6001));
    bus_wr(16'hF000, 8'h00);
  endtask

  task automatic t_misc();
    for (int p = 0; p < 8192; p += 1531) begin
      @(negedge clk);
      ppu_addr = 13'(p);
      #2 chk("R10 chr bank 0", 32'(chr_addr), p);
    end
    bus_wr(16'h8000, 8'h07);
    bus_wr(16'hE000, 8'h00);
    ppu_addr = 13'h1ABC;
    #2 chk("R10 chr after writes", 32'(chr_addr), 'h1ABC);
    bus_rd(16'h5FFF);
    chk("R13 no rom_cs", c_rom_cs, 0);
    chk("R13 no ram_cs", c_ram_cs, 0);
    bus_wr(16'h4020, 8'h10);
    chk("R13 write no we", c_ram_we, 0);
  endtask

  initial begin
    t_reset();
    t_window_rom();
    t_ram_low();
    t_overlay();
    t_fixed();
    t_writes();
    t_ignored();
    t_mirror_timing();
    t_misc();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule